// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

A 32-bit processor core that completes one instruction per clock cycle. Each cycle it fetches a word from its instruction memory at the program counter and reads two source registers. The ALU then executes, the data memory is read or written, and the result goes back to the register file. The same cycle also picks the next program counter. Eight instructions are supported: add, sub, and, or, slt, lw, sw and beq. A small decoder looks at the opcode and function fields and steers the multiplexers around a shared ALU, sign extender and pair of adders.

The instruction memory and the data memory are separate internal word arrays, so a fetch and a data access can happen in the same cycle. A load port fills either array while the core is held in reset. Observation outputs expose the fetch address, the current instruction, the register write-back port, the data-memory write port and the ALU zero flag.

Top module: `sc_cpu`

## Requirements
- R1: An active-low asynchronous reset clears the program counter to 0. After reset, the program counter advances by 4 on every rising edge unless a taken beq selects another target.
- R2: Opcode 0x00 with function code 0x20, 0x22, 0x24, 0x25 or 0x2A performs add, sub, and, or or signed set-less-than, in that pairing, on registers rs (bits 25:21) and rt (bits 20:16). The result is written to rd (bits 15:11). Any other function code with opcode 0x00 writes nothing.
- R3: Opcode 0x23 (lw) reads the data word at byte address rs + sign-extended bits 15:0 and writes it to register rt (bits 20:16).
- R4: Opcode 0x2B (sw) writes register rt to the data word at byte address rs + sign-extended bits 15:0 and does not write any register.
- R5: Opcode 0x04 (beq) subtracts rt from rs. When the difference is zero, the next program counter is PC + 4 + (sign-extended bits 15:0 shifted left by 2); otherwise it is PC + 4. A beq writes neither registers nor data memory.
- R6: Register 0 always reads as zero, and any write that targets it is discarded.
- R7: A register or data-memory word written by one instruction holds the new value for the very next instruction.
- R8: When ld_we_i is high at a rising edge, the word at word address ld_addr_i is written with ld_data_i. ld_sel_i selects the array: 0 for instruction memory, 1 for data memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_we_i | input | 1 | Memory preload write strobe |
| ld_sel_i | input | 1 | Preload target: 0 instruction, 1 data |
| ld_addr_i | input | LD_AW (6) | Preload word address |
| ld_data_i | input | 32 | Preload data word |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction fetched at pc_o |
| rf_we_o | output | 1 | Register write enable from the decoder |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Write-back value |
| dm_we_o | output | 1 | Data-memory write enable |
| dm_addr_o | output | 32 | Data byte address (ALU result) |
| dm_wdata_o | output | 32 | Data-memory write value |
| alu_zero_o | output | 1 | ALU result equals zero |

## Verification
A corrupted register shows up on rf_wdata_o or dm_wdata_o as soon as a later instruction reads that register. Directed programs therefore read back each written register one instruction later. A wrong program counter, or a wrong branch decision, shows in pc_o on the next cycle. A wrong destination select shows at once on rf_waddr_o. The programs use operands that tell apart signed and unsigned compare, positive and negative offsets, and branches that are taken and not taken in both directions.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;   // destination from rd instead of rt
    logic    imm_b;    // ALU operand b from immediate
    logic    wb_mem;   // write back memory data
    logic    rf_we;
    logic    mem_rd;
    logic    mem_wr;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = ALU_ADD;
    case (op_i)
      OP_RTYPE: begin
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.rf_we  = 1'b1;
        case (funct_i)
          FN_ADD:  ctrl_o.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.alu_op = ALU_AND;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          FN_SLT:  ctrl_o.alu_op = ALU_SLT;
          default: ctrl_o.rf_we  = 1'b0;
        endcase
      end
      OP_LW: begin
        ctrl_o.imm_b  = 1'b1;
        ctrl_o.wb_mem = 1'b1;
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.mem_rd = 1'b1;
      end
      OP_SW: begin
        ctrl_o.imm_b  = 1'b1;
        ctrl_o.mem_wr = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  always_comb begin
    case (op_i)
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_SLT: res_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: res_o = '0;
    endcase
  end
  assign zero_o = (res_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter  int NREG = 32,
  parameter  int W    = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra1_i,
  input  logic [AW-1:0] ra2_i,
  output logic [W-1:0]  rd1_o,
  output logic [W-1:0]  rd2_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign rd1_o = (ra1_i == '0) ? '0 : regs_q[ra1_i];
  assign rd2_o = (ra2_i == '0) ? '0 : regs_q[ra2_i];
endmodule

// File: rtl/sc_cpu.sv
module sc_cpu
  import sc_pkg::*;
#(
  parameter  int IMEM_WORDS = 64,
  parameter  int DMEM_WORDS = 64,
  localparam int IA_W  = $clog2(IMEM_WORDS),
  localparam int DA_W  = $clog2(DMEM_WORDS),
  localparam int LD_AW = (IA_W > DA_W) ? IA_W : DA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_we_i,
  input  logic             ld_sel_i,
  input  logic [LD_AW-1:0] ld_addr_i,
  input  logic [31:0]      ld_data_i,
  output logic [31:0]      pc_o,
  output logic [31:0]      instr_o,
  output logic             rf_we_o,
  output logic [4:0]       rf_waddr_o,
  output logic [31:0]      rf_wdata_o,
  output logic             dm_we_o,
  output logic [31:0]      dm_addr_o,
  output logic [31:0]      dm_wdata_o,
  output logic             alu_zero_o
);
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];

  logic [31:0] pc_q, pc_plus4, br_target, pc_next;
  logic [31:0] instr, imm_ext, rs_data, rt_data, alu_b, alu_res, mem_rdata;
  logic [4:0]  waddr;
  logic        zero, take_br;
  ctrl_t       ctrl;

  // fetch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  always_ff @(posedge clk_i) begin
    if (ld_we_i && !ld_sel_i) imem[ld_addr_i[IA_W-1:0]] <= ld_data_i;
  end

  assign instr     = imem[pc_q[IA_W+1:2]];
  assign pc_plus4  = pc_q + 32'd4;
  assign imm_ext   = {{16{instr[15]}}, instr[15:0]};
  assign br_target = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign take_br   = ctrl.branch && zero;
  assign pc_next   = take_br ? br_target : pc_plus4;

  sc_decoder u_dec (
    .op_i    (instr[31:26]),
    .funct_i (instr[5:0]),
    .ctrl_o  (ctrl)
  );

  assign waddr = ctrl.dst_rd ? instr[15:11] : instr[20:16];

  sc_regfile #(.NREG(32), .W(32)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra1_i  (instr[25:21]),
    .ra2_i  (instr[20:16]),
    .rd1_o  (rs_data),
    .rd2_o  (rt_data),
    .we_i   (ctrl.rf_we),
    .wa_i   (waddr),
    .wd_i   (rf_wdata_o)
  );

  assign alu_b = ctrl.imm_b ? imm_ext : rt_data;

  sc_alu #(.W(32)) u_alu (
    .a_i    (rs_data),
    .b_i    (alu_b),
    .op_i   (ctrl.alu_op),
    .res_o  (alu_res),
    .zero_o (zero)
  );

  // data memory; preload has priority over a core store
  always_ff @(posedge clk_i) begin
    if (ld_we_i && ld_sel_i)  dmem[ld_addr_i[DA_W-1:0]] <= ld_data_i;
    else if (ctrl.mem_wr)     dmem[alu_res[DA_W+1:2]]   <= rt_data;
  end

  assign mem_rdata = ctrl.mem_rd ? dmem[alu_res[DA_W+1:2]] : '0;

  assign pc_o       = pc_q;
  assign instr_o    = instr;
  assign rf_we_o    = ctrl.rf_we;
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = ctrl.wb_mem ? mem_rdata : alu_res;
  assign dm_we_o    = ctrl.mem_wr;
  assign dm_addr_o  = alu_res;
  assign dm_wdata_o = rt_data;
  assign alu_zero_o = zero;
endmodule

// File: rtl/sc_cpu_chk.sv
module sc_cpu_chk
  import sc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_o,
  input logic [31:0] instr_o,
  input logic        rf_we_o,
  input logic [4:0]  rf_waddr_o,
  input logic [31:0] rf_wdata_o,
  input logic        dm_we_o,
  input logic        alu_zero_o
);
  logic [5:0]  op;
  logic        is_taken;
  logic [31:0] br_off;

  assign op       = instr_o[31:26];
  assign is_taken = (op == OP_BEQ) && alu_zero_o;
  assign br_off   = {{14{instr_o[15]}}, instr_o[15:0], 2'b00};

  p_pc_seq_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_taken |=> pc_o == $past(pc_o) + 32'd4);

  p_rtype_dest_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_RTYPE && rf_we_o) |-> rf_waddr_o == instr_o[15:11]);

  p_lw_dest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_LW) |-> (rf_we_o && !dm_we_o && rf_waddr_o == instr_o[20:16]));

  p_sw_nowb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SW) |-> (dm_we_o && !rf_we_o));

  p_beq_nowrite_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BEQ) |-> (!dm_we_o && !rf_we_o));

  p_beq_target_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_taken |=> pc_o == $past(pc_o) + 32'd4 + $past(br_off));

  p_r0_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_RTYPE && instr_o[5:0] == FN_ADD && instr_o[25:16] == 10'd0)
      |-> rf_wdata_o == 32'd0);
endmodule

bind sc_cpu sc_cpu_chk u_chk (.*);

// File: tb/sc_cpu_test.sv
`timescale 1ns/1ps
module sc_cpu_test;
  import sc_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_we_i = 1'b0;
  logic        ld_sel_i = 1'b0;
  logic [5:0]  ld_addr_i = '0;
  logic [31:0] ld_data_i = '0;
  logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [4:0]  rf_waddr_o;
  logic        rf_we_o, dm_we_o, alu_zero_o;

  int n_run  = 0;
  int n_fail = 0;
  logic [31:0] prog  [64];
  logic [31:0] dinit [64];

  always #4 clk_i = ~clk_i;

  sc_cpu uut (.*);

  function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
    return {OP_RTYPE, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt,
                                        input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // expect a register write (or none) at the current instruction
  task automatic exp_wb(input string req, input logic [31:0] pc, input logic we,
                        input logic [4:0] wa, input logic [31:0] wd);
    chk(req, "pc", pc_o, pc);
    chk(req, "rf_we", {31'd0, rf_we_o}, {31'd0, we});
    if (we) begin
      chk(req, "rf_waddr", {27'd0, rf_waddr_o}, {27'd0, wa});
      chk(req, "rf_wdata", rf_wdata_o, wd);
    end
  endtask

  task automatic clear_images();
    for (int i = 0; i < 64; i++) begin
      prog[i]  = '0;
      dinit[i] = '0;
    end
  endtask

  // R8: preload both arrays under reset, then release
  task automatic load_and_run();
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 64; i++) begin
      ld_we_i = 1'b1; ld_sel_i = 1'b0; ld_addr_i = 6'(i); ld_data_i = prog[i];
      @(negedge clk_i);
    end
    for (int i = 0; i < 64; i++) begin
      ld_we_i = 1'b1; ld_sel_i = 1'b1; ld_addr_i = 6'(i); ld_data_i = dinit[i];
      @(negedge clk_i);
    end
    ld_we_i = 1'b0;
    chk("R1", "pc in reset", pc_o, 32'd0);
    rst_ni = 1'b1;
  endtask

  task automatic t_alu();
    clear_images();
    dinit[0] = 32'd7;
    dinit[1] = 32'hFFFF_FFFD;
    prog[0] = enc_i(OP_LW, 0, 1, 16'd0);
    prog[1] = enc_i(OP_LW, 0, 2, 16'd4);
    prog[2] = enc_r(1, 2, 3, FN_ADD);
    prog[3] = enc_r(1, 2, 4, FN_SUB);
    prog[4] = enc_r(1, 2, 5, FN_AND);
    prog[5] = enc_r(1, 2, 6, FN_OR);
    prog[6] = enc_r(2, 1, 7, FN_SLT);
    prog[7] = enc_r(1, 2, 8, FN_SLT);
    prog[8] = enc_i(OP_BEQ, 0, 0, 16'hFFFF);
    load_and_run();
    exp_wb("R8", 32'd0, 1'b1, 5'd1, 32'd7);
    chk("R3", "lw addr", dm_addr_o, 32'd0);
    step(); exp_wb("R8", 32'd4, 1'b1, 5'd2, 32'hFFFF_FFFD);
    chk("R3", "lw addr", dm_addr_o, 32'd4);
    step(); exp_wb("R2", 32'd8,  1'b1, 5'd3, 32'd4);
    step(); exp_wb("R2", 32'd12, 1'b1, 5'd4, 32'd10);
    step(); exp_wb("R2", 32'd16, 1'b1, 5'd5, 32'd5);
    step(); exp_wb("R2", 32'd20, 1'b1, 5'd6, 32'hFFFF_FFFF);
    step(); exp_wb("R2", 32'd24, 1'b1, 5'd7, 32'd1);
    step(); exp_wb("R2", 32'd28, 1'b1, 5'd8, 32'd0);
    step(); exp_wb("R5", 32'd32, 1'b0, 5'd0, 32'd0);
    step(); exp_wb("R5", 32'd32, 1'b0, 5'd0, 32'd0);
  endtask

  task automatic t_mem();
    clear_images();
    dinit[2] = 32'h1234_5678;
    dinit[3] = 32'h0000_0040;
    prog[0] = enc_i(OP_LW, 0, 1, 16'd12);
    prog[1] = enc_i(OP_LW, 0, 9, 16'd8);
    prog[2] = enc_i(OP_SW, 1, 9, 16'hFFFC);
    prog[3] = enc_i(OP_LW, 1, 10, 16'hFFFC);
    prog[4] = enc_r(9, 9, 0, FN_ADD);
    prog[5] = enc_r(0, 1, 11, FN_ADD);
    prog[6] = enc_i(OP_BEQ, 0, 0, 16'hFFFF);
    load_and_run();
    exp_wb("R3", 32'd0, 1'b1, 5'd1, 32'h40);
    step(); exp_wb("R3", 32'd4, 1'b1, 5'd9, 32'h1234_5678);
    step(); exp_wb("R4", 32'd8, 1'b0, 5'd0, 32'd0);
    chk("R4", "dm_we", {31'd0, dm_we_o}, 32'd1);
    chk("R4", "dm_addr negative offset", dm_addr_o, 32'h3C);
    chk("R4", "dm_wdata", dm_wdata_o, 32'h1234_5678);
    step(); exp_wb("R7", 32'd12, 1'b1, 5'd10, 32'h1234_5678);
    chk("R7", "dm_we on lw", {31'd0, dm_we_o}, 32'd0);
    step(); exp_wb("R6", 32'd16, 1'b1, 5'd0, 32'h2468_ACF0);
    step(); exp_wb("R6", 32'd20, 1'b1, 5'd11, 32'h40);
    step(); exp_wb("R1", 32'd24, 1'b0, 5'd0, 32'd0);
  endtask

  task automatic t_branch();
    clear_images();
    dinit[0] = 32'd5;
    dinit[1] = 32'd5;
    dinit[2] = 32'd6;
    prog[0] = enc_i(OP_LW, 0, 1, 16'd0);
    prog[1] = enc_i(OP_LW, 0, 2, 16'd4);
    prog[2] = enc_i(OP_LW, 0, 3, 16'd8);
    prog[3] = enc_i(OP_BEQ, 1, 3, 16'd5);
    prog[4] = enc_i(OP_BEQ, 1, 2, 16'd2);
    prog[5] = enc_r(1, 1, 12, FN_ADD);
    prog[6] = enc_i(OP_BEQ, 0, 0, 16'hFFFF);
    prog[7] = enc_i(OP_BEQ, 0, 0, 16'hFFFD);
    prog[5] = enc_r(1, 3, 4, FN_ADD);
    load_and_run();
    step(); step();
    step(); exp_wb("R5", 32'd12, 1'b0, 5'd0, 32'd0);
    chk("R5", "zero not equal", {31'd0, alu_zero_o}, 32'd0);
    chk("R5", "dm_we on beq", {31'd0, dm_we_o}, 32'd0);
    step(); exp_wb("R1", 32'd16, 1'b0, 5'd0, 32'd0);
    chk("R5", "zero equal", {31'd0, alu_zero_o}, 32'd1);
    step(); exp_wb("R5", 32'd28, 1'b0, 5'd0, 32'd0);
    step(); exp_wb("R5", 32'd20, 1'b1, 5'd4, 32'd11);
    step(); exp_wb("R5", 32'd24, 1'b0, 5'd0, 32'd0);
    step(); exp_wb("R5", 32'd24, 1'b0, 5'd0, 32'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    t_alu();
    t_mem();
    t_branch();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule